// File: doc/BRIEF.md
# PRBS Packet Generator and Checker

This block is a self-test engine for a serial data path. Its generator sends test packets one bit per clock. A packet is either pseudo-random payload, repeated back to back with an idle gap between packets, or a single packet of a fixed byte pattern. Its checker takes a received bit stream qualified by a valid strobe and locks onto the pseudo-random sequence without needing to know the sequence's phase. Once locked, it counts every mismatching bit.

The checker reports three things: a lock flag, a sync-loss flag that stays set until a status read, and an error counter. The counter either stops at its maximum or wraps to zero with a one-cycle pulse. To test a path, loop the transmit bits back to the receive input, enable the generator with the PRBS-packet select set, and watch lock and the error count. The checker also runs alone when the PRBS-packet select is set and the generator is off.

Top module: `prbs_bist`

## Requirements
- R1: With `gen_en` and `prbs_pkt` high, each packet carries 512 payload bits with `tx_valid` high. The payload comes from a 15-bit LFSR with polynomial x^15 + x^14 + 1. The register is all ones after reset. Each payload bit is the XOR of register bits 14 and 13, and that bit is then shifted into bit 0. The register advances only on PRBS payload bits and keeps its value between runs.
- R2: In PRBS mode, packets repeat with exactly 96 cycles of `tx_valid` low between them. `gen_active` is high during payload and gap cycles, and `tx_valid` never rises while `gen_active` is low.
- R3: With `gen_en` high and `prbs_pkt` low, exactly one packet of 512 bits is sent. It is the byte 0xA5 repeated, least significant bit first. `gen_active` then stays low until `gen_en` is cleared and set again. The LFSR does not advance in this mode.
- R4: Clearing `gen_en` stops the generator at the next clock edge, with `tx_valid` and `gen_active` low.
- R5: The checker runs whenever `prbs_pkt` is high, whatever the value of `gen_en`. While `prbs_pkt` is low, the checker is held unsynchronised, `lock` is low one edge later, and `err_cnt` keeps its value.
- R6: Bits with `rx_valid` low are ignored. The checker loads its register from 15 valid bits. It raises `lock` on the edge of the 32nd following error-free valid bit, which is the 47th valid bit of a clean stream. Any mismatch before lock restarts loading.
- R7: While locked, each valid bit that differs from the predicted bit adds one to `err_cnt` on the edge of that bit. A single flipped bit counts as exactly one error.
- R8: While locked, the first error opens a window of 64 valid bits. Eight errors inside one window drop `lock` and set `sync_loss` on the edge of the eighth error, and the checker then reloads. Fewer errors in a window keep `lock`.
- R9: `sync_loss` stays high until a cycle with `stat_rd` high, and it is low after that edge. A new loss in the same cycle as the read wins.
- R10: With `cnt_wrap` low, `err_cnt` stops at 255 and further errors leave it there, with no `err_wrap` pulse.
- R11: With `cnt_wrap` high, an error at count 255 sets `err_cnt` to 0 and raises `err_wrap` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Generator enable |
| prbs_pkt | input | 1 | 1: PRBS packets and checker on; 0: one fixed-byte packet, checker off |
| cnt_wrap | input | 1 | 1: error counter wraps; 0: error counter saturates |
| rx_bit | input | 1 | Received bit |
| rx_valid | input | 1 | Qualifies `rx_bit` |
| stat_rd | input | 1 | Status read strobe, clears `sync_loss` |
| tx_bit | output | 1 | Transmitted bit |
| tx_valid | output | 1 | High on payload bits |
| gen_active | output | 1 | Generator producing a packet or gap |
| lock | output | 1 | Checker synchronised |
| sync_loss | output | 1 | Latched loss of lock |
| err_cnt | output | 8 | Bit error count |
| err_wrap | output | 1 | One-cycle pulse when the counter wraps |

## Verification
The first transmitted bit appears one edge after `gen_en` is sampled high. Every later payload or gap cycle follows one edge apart. `lock`, `err_cnt`, `err_wrap` and `sync_loss` change on the same edge that consumes the deciding received bit. A read clears `sync_loss` one edge after `stat_rd`. The bench drives every input just after a falling edge and reads the outputs at the next falling edge, one rising edge later. In this way each result is compared in the exact cycle in which it is due, against bit-exact LFSR models and error tallies computed in the bench.

// File: rtl/prbs_bist.sv
module prbs_bist #(
  parameter int CNT_W     = 8,
  parameter int PKT_BYTES = 64,
  parameter int GAP_BYTES = 12,
  parameter int LOCK_BITS = 32,
  parameter int WIN_BITS  = 64,
  parameter int LOSS_ERRS = 8,
  parameter logic [7:0] FILL_BYTE = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             prbs_pkt,
  input  logic             cnt_wrap,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             stat_rd,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             gen_active,
  output logic             lock,
  output logic             sync_loss,
  output logic [CNT_W-1:0] err_cnt,
  output logic             err_wrap
);
  localparam int PAY_BITS = PKT_BYTES * 8;
  localparam int GAP_BITS = GAP_BYTES * 8;
  localparam int BW = $clog2(PAY_BITS + GAP_BITS);
  localparam int SW = $clog2(LOCK_BITS + 15);
  localparam int WW = $clog2(WIN_BITS) + 1;
  localparam int EW = $clog2(LOSS_ERRS) + 1;

  typedef enum logic [1:0] {G_IDLE, G_PAY, G_GAP, G_DONE} gen_st_t;
  typedef enum logic [1:0] {C_SEED, C_HUNT, C_LOCK} chk_st_t;

  gen_st_t gst;
  logic [14:0] glfsr;
  logic [BW-1:0] gcnt;
  logic gmode;
  logic gfb;

  assign gfb        = glfsr[14] ^ glfsr[13];
  assign tx_valid   = (gst == G_PAY);
  assign tx_bit     = tx_valid & (gmode ? gfb : FILL_BYTE[gcnt[2:0]]);
  assign gen_active = (gst == G_PAY) || (gst == G_GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gst   <= G_IDLE;
      gcnt  <= '0;
      glfsr <= '1;
      gmode <= 1'b0;
    end else if (!gen_en) begin
      gst  <= G_IDLE;
      gcnt <= '0;
    end else begin
      case (gst)
        G_IDLE: begin
          gst   <= G_PAY;
          gmode <= prbs_pkt;
          gcnt  <= '0;
        end
        G_PAY: begin
          if (gmode) glfsr <= {glfsr[13:0], gfb};
          if (gcnt == BW'(PAY_BITS - 1)) begin
            gcnt <= '0;
            gst  <= gmode ? G_GAP : G_DONE;
          end else gcnt <= gcnt + 1'b1;
        end
        G_GAP: begin
          if (gcnt == BW'(GAP_BITS - 1)) begin
            gcnt <= '0;
            gst  <= G_PAY;
          end else gcnt <= gcnt + 1'b1;
        end
        default: gst <= G_DONE;
      endcase
    end
  end

  chk_st_t cst;
  logic [14:0] csh;
  logic [SW-1:0] ccnt;
  logic wopen;
  logic [WW-1:0] wcnt;
  logic [EW-1:0] werr;
  logic pred, miss, hit;

  assign pred = csh[14] ^ csh[13];
  assign miss = rx_bit ^ pred;
  assign lock = (cst == C_LOCK);
  assign hit  = prbs_pkt & rx_valid & lock & miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst       <= C_SEED;
      csh       <= '0;
      ccnt      <= '0;
      wopen     <= 1'b0;
      wcnt      <= '0;
      werr      <= '0;
      sync_loss <= 1'b0;
    end else begin
      if (stat_rd) sync_loss <= 1'b0;
      if (!prbs_pkt) begin
        cst   <= C_SEED;
        ccnt  <= '0;
        wopen <= 1'b0;
        wcnt  <= '0;
        werr  <= '0;
      end else if (rx_valid) begin
        case (cst)
          C_SEED: begin
            csh <= {csh[13:0], rx_bit};
            if (ccnt == SW'(14)) begin
              cst  <= C_HUNT;
              ccnt <= '0;
            end else ccnt <= ccnt + 1'b1;
          end
          C_HUNT: begin
            csh <= {csh[13:0], pred};
            if (miss) begin
              cst  <= C_SEED;
              ccnt <= '0;
            end else if (ccnt == SW'(LOCK_BITS - 1)) begin
              cst  <= C_LOCK;
              ccnt <= '0;
            end else ccnt <= ccnt + 1'b1;
          end
          default: begin
            csh <= {csh[13:0], pred};
            if (wopen) begin
              if (miss && werr == EW'(LOSS_ERRS - 1)) begin
                cst       <= C_SEED;
                sync_loss <= 1'b1;
                wopen     <= 1'b0;
                wcnt      <= '0;
                werr      <= '0;
              end else if (wcnt == WW'(WIN_BITS - 1)) begin
                wopen <= miss;
                wcnt  <= WW'(miss);
                werr  <= EW'(miss);
              end else begin
                wcnt <= wcnt + 1'b1;
                werr <= werr + EW'(miss);
              end
            end else if (miss) begin
              wopen <= 1'b1;
              wcnt  <= WW'(1);
              werr  <= EW'(1);
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      err_wrap <= 1'b0;
    end else begin
      err_wrap <= 1'b0;
      if (hit) begin
        if (err_cnt == '1) begin
          if (cnt_wrap) begin
            err_cnt  <= '0;
            err_wrap <= 1'b1;
          end
        end else err_cnt <= err_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prbs_bist_chk.sv
module prbs_bist_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             prbs_pkt,
  input logic             cnt_wrap,
  input logic             tx_valid,
  input logic             gen_active,
  input logic             lock,
  input logic             sync_loss,
  input logic [CNT_W-1:0] err_cnt,
  input logic             err_wrap
);
  // R2
  tx_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> gen_active);

  // R4
  gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !gen_active);

  // R5
  chk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prbs_pkt |=> !lock);

  // R7
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_wrap |-> (err_cnt == $past(err_cnt) || err_cnt == CNT_W'($past(err_cnt) + 1'b1)));

  // R8
  loss_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_loss) |-> $fell(lock));

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == '1 && !cnt_wrap) |=> (err_cnt == '1));

  // R11
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_wrap |-> (err_cnt == '0));

  // R11
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_wrap |=> !err_wrap);
endmodule

bind prbs_bist prbs_bist_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .prbs_pkt(prbs_pkt),
  .cnt_wrap(cnt_wrap), .tx_valid(tx_valid), .gen_active(gen_active),
  .lock(lock), .sync_loss(sync_loss), .err_cnt(err_cnt), .err_wrap(err_wrap)
);

// File: tb/prbs_bist_tb.sv
module prbs_bist_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n, gen_en, prbs_pkt, cnt_wrap, stat_rd;
  logic drv_bit, drv_valid, loop_on;
  logic rx_bit, rx_valid;
  logic tx_bit, tx_valid, gen_active, lock, sync_loss, err_wrap;
  logic [7:0] err_cnt;

  int n_run = 0;
  int n_fail = 0;
  int n_pulse = 0;
  logic [14:0] gm;
  logic [14:0] bl;

  always #(CLK_NS / 2) clk = ~clk;

  assign rx_bit   = loop_on ? tx_bit : drv_bit;
  assign rx_valid = loop_on ? tx_valid : drv_valid;

  prbs_bist dut_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .prbs_pkt(prbs_pkt),
    .cnt_wrap(cnt_wrap), .rx_bit(rx_bit), .rx_valid(rx_valid), .stat_rd(stat_rd),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .gen_active(gen_active), .lock(lock),
    .sync_loss(sync_loss), .err_cnt(err_cnt), .err_wrap(err_wrap)
  );

  always @(negedge clk) if (rst_n && err_wrap) n_pulse++;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gen_en = 1'b0; prbs_pkt = 1'b0; cnt_wrap = 1'b0;
    stat_rd = 1'b0; loop_on = 1'b0; drv_bit = 1'b0; drv_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_pulse = 0;
  endtask

  task automatic feed(input logic flip);
    logic nb;
    nb = bl[14] ^ bl[13];
    bl = {bl[13:0], nb};
    drv_bit = nb ^ flip;
    drv_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic feed_idle();
    drv_bit = ~(bl[14] ^ bl[13]);
    drv_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic feed_clean(input int n);
    for (int i = 0; i < n; i++) feed(1'b0);
  endtask

  task automatic err_round();
    for (int i = 0; i < 7; i++) begin
      feed(1'b1);
      if (i < 6) feed(1'b0);
    end
    feed_clean(80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int bad, gap, seen;
    @(negedge clk);
    do_reset();
    chk("reset R2 gen_active", gen_active, 0);
    chk("reset R6 lock", lock, 0);
    chk("reset R9 sync_loss", sync_loss, 0);
    chk("reset R7 err_cnt", err_cnt, 0);

    // R3: one fixed-byte packet
    gen_en = 1'b1; prbs_pkt = 1'b0;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 512; i++) begin
      if (!tx_valid || tx_bit !== ((8'hA5 >> (i % 8)) & 1)) bad++;
      @(negedge clk);
    end
    chk("R3 fixed payload mismatches", bad, 0);
    chk("R3 gen_active after packet", gen_active, 0);
    seen = 0;
    for (int i = 0; i < 700; i++) begin
      if (tx_valid) seen++;
      @(negedge clk);
    end
    chk("R3 no second packet", seen, 0);
    gen_en = 1'b0; @(negedge clk);
    gen_en = 1'b1; @(negedge clk);
    chk("R3 restart after re-enable", tx_valid, 1);
    repeat (100) @(negedge clk);
    // R4
    gen_en = 1'b0; @(negedge clk);
    chk("R4 tx_valid after disable", tx_valid, 0);
    chk("R4 gen_active after disable", gen_active, 0);

    // R1, R2, R6 in loopback
    do_reset();
    loop_on = 1'b1; prbs_pkt = 1'b1; gen_en = 1'b1;
    gm = 15'h7FFF;
    for (int p = 0; p < 3; p++) begin
      gap = 0; bad = 0;
      while (!tx_valid) begin
        if (p > 0 && !gen_active) bad++;
        @(negedge clk);
        gap++;
      end
      if (p > 0) begin
        chk("R2 gap length", gap, 96);
        chk("R2 gen_active in gap", bad, 0);
      end
      bad = 0;
      for (int i = 0; i < 512; i++) begin
        logic e;
        e = gm[14] ^ gm[13];
        gm = {gm[13:0], e};
        if (!tx_valid || tx_bit !== e || !gen_active) bad++;
        @(negedge clk);
      end
      chk("R1 PRBS payload mismatches", bad, 0);
      if (p == 0) chk("R6 lock in loopback", lock, 1);
    end
    chk("R7 loopback errors", err_cnt, 0);
    chk("R6 lock held across gaps", lock, 1);
    gen_en = 1'b0; loop_on = 1'b0;

    // R5, R6, R7, R8, R9 with generator off
    do_reset();
    prbs_pkt = 1'b1;
    bl = 15'h1234;
    for (int i = 0; i < 46; i++) begin
      feed(1'b0);
      if (i % 3 == 0) feed_idle();
    end
    chk("R6 lock before 47th bit", lock, 0);
    feed(1'b0);
    chk("R6 lock on 47th bit", lock, 1);
    chk("R5 checker runs with gen off", lock, 1);
    for (int k = 0; k < 3; k++) begin feed(1'b1); feed_clean(10); end
    feed_clean(70);
    chk("R7 three flipped bits", err_cnt, 3);
    for (int k = 0; k < 7; k++) begin feed(1'b1); feed_clean(7); end
    feed_clean(80);
    chk("R8 seven errors keep lock", lock, 1);
    chk("R8 seven errors no sync_loss", sync_loss, 0);
    chk("R7 count after ten", err_cnt, 10);
    for (int k = 0; k < 7; k++) feed(1'b1);
    chk("R8 lock before eighth error", lock, 1);
    feed(1'b1);
    chk("R8 lock dropped", lock, 0);
    chk("R8 sync_loss set", sync_loss, 1);
    chk("R7 count after loss", err_cnt, 18);
    feed_clean(100);
    chk("R6 relock", lock, 1);
    chk("R9 sync_loss latched", sync_loss, 1);
    stat_rd = 1'b1; feed(1'b0); stat_rd = 1'b0;
    chk("R9 sync_loss cleared by read", sync_loss, 0);
    prbs_pkt = 1'b0; feed(1'b0);
    chk("R5 lock low when disabled", lock, 0);
    feed_clean(100);
    chk("R5 no lock while disabled", lock, 0);
    chk("R5 err_cnt held", err_cnt, 18);

    // R10 saturation
    do_reset();
    prbs_pkt = 1'b1; cnt_wrap = 1'b0;
    feed_clean(47);
    for (int r = 0; r < 38; r++) err_round();
    chk("R10 saturated count", err_cnt, 255);
    chk("R10 no wrap pulse", n_pulse, 0);
    chk("R10 lock kept", lock, 1);

    // R11 wrap
    do_reset();
    prbs_pkt = 1'b1; cnt_wrap = 1'b1;
    feed_clean(47);
    for (int r = 0; r < 36; r++) err_round();
    chk("R11 count 252", err_cnt, 252);
    for (int k = 0; k < 3; k++) begin feed(1'b1); feed_clean(15); end
    chk("R11 count 255", err_cnt, 255);
    feed(1'b1);
    chk("R11 wrapped to zero", err_cnt, 0);
    chk("R11 pulse high", err_wrap, 1);
    feed(1'b0);
    chk("R11 pulse one cycle", err_wrap, 0);
    chk("R11 pulse count", n_pulse, 1);
    feed_clean(80);
    for (int k = 0; k < 4; k++) begin feed(1'b1); feed_clean(10); end
    chk("R11 counts on from zero", err_cnt, 4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule